// File: doc/BRIEF.md
# DDR2 Refresh Command Scheduler

This block keeps a DDR2 SDRAM refreshed on behalf of a memory controller. A free-running tick counter, sized from the clock period, marks the end of each refresh interval. Each expiry adds one refresh to a small debt counter. While the debt is non-zero the block asks the command arbiter for the bus. A second output signals that the debt is full and the refresh must not wait any longer. When the arbiter grants the bus, the block closes all banks with a precharge-all if any bank is open. It then waits the row precharge time, issues REFRESH and holds the bus with NOPs until the refresh cycle time has passed.

The interval shortens to the high-temperature value while the hot-case input is set. Using the normal interval keeps every row refreshed within a 64 ms window. The intervals and the tRP and tRFC guard times are given in picoseconds and converted to clock cycles at elaboration. The intervals round down and the guard times round up.

Top module: `ddr2_refresh_sched`

## Requirements
- R1: While rst_n is low: ref_req_o=0, ref_urgent_o=0, ref_busy_o=0, cke_o=0, a10_o=0, and cmd_o shows deselect. The command code {cs_n,ras_n,cas_n,we_n} is 4'b1111 for deselect, 4'b0111 for NOP, 4'b0010 for precharge and 4'b0001 for REFRESH.
- R2: With temp_hot_i low, one refresh becomes pending every N_NORM = floor(TREFI_NORM_PS/CLK_PS) cycles. After reset release, ref_req_o is still low after N_NORM-1 rising edges and is high after N_NORM edges.
- R3: With temp_hot_i high, the same rule uses N_HOT = floor(TREFI_HOT_PS/CLK_PS).
- R4: If bank_open_i is high on the edge where ref_grant_i and ref_req_o are both high, the next cycle drives precharge with a10_o=1 and ref_busy_o=1.
- R5: REFRESH follows exactly TRP = ceil(TRP_PS/CLK_PS) cycles after the precharge cycle, with NOP in between.
- R6: If bank_open_i is low at the grant edge, REFRESH is driven in the next cycle with no precharge.
- R7: After the REFRESH cycle, NOP is driven for TRFC-1 cycles, where TRFC = ceil(TRFC_PS/CLK_PS). ref_busy_o drops TRFC cycles after REFRESH, so two back-to-back REFRESH commands are at least TRFC cycles apart.
- R8: Each REFRESH removes one pending refresh, and ref_req_o falls once none remain. A grant with no pending refresh is ignored: busy stays low and cmd_o stays deselect.
- R9: The pending count saturates at MAX_PEND (8). ref_urgent_o is high exactly while the count is full. Expiries arriving while it is full are lost, so after 9 intervals exactly 8 refreshes clear the debt.
- R10: cke_o is high from the first edge after reset and stays high throughout every sequence.
- R11: Changes on bank_open_i or ref_grant_i while busy do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| temp_hot_i | input | 1 | Case temperature above the high threshold |
| bank_open_i | input | 1 | At least one bank is active |
| ref_grant_i | input | 1 | Arbiter hands the command bus to this block |
| ref_req_o | output | 1 | At least one refresh pending |
| ref_urgent_o | output | 1 | Pending refresh count is full |
| ref_busy_o | output | 1 | Block owns the command bus |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 4 | Command code {cs_n,ras_n,cas_n,we_n} |
| a10_o | output | 1 | Address bit 10 (all-bank select on precharge) |

## Verification
Inputs change on the falling edge and outputs are read on the falling edge, half a cycle after the edge that changes them. The request is due exactly N rising edges after reset release, so the bench reads it at N-1 and at N edges. Precharge or REFRESH appears in the cycle after the grant edge. REFRESH comes TRP cycles after precharge, and busy drops TRFC cycles after REFRESH. The bench follows each sequence cycle by cycle and compares every cycle's command against the value due in that cycle. For saturation, the bench counts REFRESH commands and the spacing between them while the grant is held high.

// File: rtl/ddr2_ref_pkg.sv
`timescale 1ns/1ps
package ddr2_ref_pkg;

  // Command code as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } ref_cmd_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PRE  = 2'd1,
    SEQ_REF  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/ddr2_ref_tick.sv
`timescale 1ns/1ps
module ddr2_ref_tick #(
  parameter int N_NORM = 3125,
  parameter int N_HOT  = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  output logic expire_o
);
  localparam int CW = $clog2(N_NORM);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  always_comb begin
    limit    = hot_i ? CW'(N_HOT - 1) : CW'(N_NORM - 1);
    expire_o = (cnt_q >= limit);
    cnt_en   = 1'b1;
    cnt_d    = expire_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (N_HOT > 1) begin : g_gap_chk
      // two expiries never fall on adjacent cycles
      assert_expire_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    end
  endgenerate

endmodule

// File: rtl/ddr2_ref_debt.sv
`timescale 1ns/1ps
module ddr2_ref_debt #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add_i,
  input  logic take_i,
  output logic req_o,
  output logic urgent_o
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend_q, pend_d;
  logic          full, inc, dec, pend_en;

  always_comb begin
    full    = (pend_q == PW'(MAX_PEND));
    inc     = add_i && !full;
    dec     = take_i && (pend_q != '0);
    pend_en = inc ^ dec;
    pend_d  = inc ? pend_q + 1'b1 : pend_q - 1'b1;
    req_o    = (pend_q != '0);
    urgent_o = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(MAX_PEND));

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_o && add_i && !take_i) |=> urgent_o);

  // the sequencer only issues a refresh that is owed
  assert_take_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> req_o);

endmodule

// File: rtl/ddr2_ref_seq.sv
`timescale 1ns/1ps
module ddr2_ref_seq
  import ddr2_ref_pkg::*;
#(
  parameter int TRP  = 5,
  parameter int TRFC = 79
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_i,
  input  logic     grant_i,
  input  logic     bank_open_i,
  output logic     busy_o,
  output logic     cke_o,
  output ref_cmd_e cmd_o,
  output logic     a10_o,
  output logic     issue_o
);
  localparam int LIM = (TRFC > TRP) ? TRFC : TRP;
  localparam int WW  = $clog2(LIM + 1);

  seq_state_e    state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          cke_q;

  // next-state process
  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req_i && grant_i) begin
          state_d = bank_open_i ? SEQ_PRE : SEQ_REF;
          wcnt_d  = '0;
        end
      end
      SEQ_PRE: begin
        if (wcnt_q == WW'(TRP - 1)) begin
          state_d = SEQ_REF;
          wcnt_d  = '0;
        end else begin
          wcnt_d  = wcnt_q + 1'b1;
        end
      end
      SEQ_REF: begin
        if (wcnt_q == WW'(TRFC - 1)) begin
          state_d = SEQ_IDLE;
          wcnt_d  = '0;
        end else begin
          wcnt_d  = wcnt_q + 1'b1;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        wcnt_d  = '0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      wcnt_q  <= '0;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      cke_q   <= 1'b1;
    end
  end

  // output decode
  always_comb begin
    cmd_o   = CMD_DESEL;
    a10_o   = 1'b0;
    issue_o = 1'b0;
    busy_o  = (state_q != SEQ_IDLE);
    cke_o   = cke_q;
    unique case (state_q)
      SEQ_PRE: begin
        cmd_o = (wcnt_q == '0) ? CMD_PRE : CMD_NOP;
        a10_o = (wcnt_q == '0);
      end
      SEQ_REF: begin
        cmd_o   = (wcnt_q == '0) ? CMD_REF : CMD_NOP;
        issue_o = (wcnt_q == '0);
      end
      default: ;
    endcase
  end

  // guard-time monitors: cycles since the last precharge / refresh
  logic [WW-1:0] since_pre_q, since_ref_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre_q <= WW'(LIM);
      since_ref_q <= WW'(LIM);
    end else begin
      if (cmd_o == CMD_PRE)            since_pre_q <= WW'(1);
      else if (since_pre_q < WW'(LIM)) since_pre_q <= since_pre_q + 1'b1;
      if (cmd_o == CMD_REF)            since_ref_q <= WW'(1);
      else if (since_ref_q < WW'(LIM)) since_ref_q <= since_ref_q + 1'b1;
    end
  end

  assert_pre_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> a10_o);

  assert_trp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF) |-> (since_pre_q >= WW'(TRP)));

  assert_trfc_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != CMD_NOP) && (cmd_o != CMD_DESEL)) |-> (since_ref_q >= WW'(TRFC)));

  assert_cke_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cke_o);

endmodule

// File: rtl/ddr2_refresh_sched.sv
`timescale 1ns/1ps
module ddr2_refresh_sched
  import ddr2_ref_pkg::*;
#(
  parameter int CLK_PS        = 2500,
  parameter int TREFI_NORM_PS = 7812500,
  parameter int TREFI_HOT_PS  = 3900000,
  parameter int TRP_PS        = 12500,
  parameter int TRFC_PS       = 197500,
  parameter int MAX_PEND      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       temp_hot_i,
  input  logic       bank_open_i,
  input  logic       ref_grant_i,
  output logic       ref_req_o,
  output logic       ref_urgent_o,
  output logic       ref_busy_o,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       a10_o
);
  localparam int N_NORM   = TREFI_NORM_PS / CLK_PS;
  localparam int N_HOT    = TREFI_HOT_PS / CLK_PS;
  localparam int TRP_CYC  = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRFC_CYC = (TRFC_PS + CLK_PS - 1) / CLK_PS;

  logic     expire, issue;
  ref_cmd_e cmd;

  ddr2_ref_tick #(.N_NORM(N_NORM), .N_HOT(N_HOT)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .hot_i    (temp_hot_i),
    .expire_o (expire)
  );

  ddr2_ref_debt #(.MAX_PEND(MAX_PEND)) u_debt (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_i    (expire),
    .take_i   (issue),
    .req_o    (ref_req_o),
    .urgent_o (ref_urgent_o)
  );

  ddr2_ref_seq #(.TRP(TRP_CYC), .TRFC(TRFC_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (ref_req_o),
    .grant_i     (ref_grant_i),
    .bank_open_i (bank_open_i),
    .busy_o      (ref_busy_o),
    .cke_o       (cke_o),
    .cmd_o       (cmd),
    .a10_o       (a10_o),
    .issue_o     (issue)
  );

  assign cmd_o = cmd;

endmodule

// File: tb/test_ddr2_refresh_sched.sv
`timescale 1ns/1ps
module test_ddr2_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS = 2500;
  localparam int NN   = 7812500 / CLK_PS;
  localparam int NH   = 3900000 / CLK_PS;
  localparam int TRP  = (12500 + CLK_PS - 1) / CLK_PS;
  localparam int TRFC = (197500 + CLK_PS - 1) / CLK_PS;
  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111,
                         C_PRE = 4'b0010, C_REF = 4'b0001;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic temp_hot = 1'b0, bank_open = 1'b0, grant = 1'b0;
  logic req, urgent, busy, cke, a10;
  logic [3:0] cmd;
  int checks = 0, failures = 0, cycles = 0;

  ddr2_refresh_sched i_ddr2_refresh_sched (
    .clk(clk), .rst_n(rst_n), .temp_hot_i(temp_hot), .bank_open_i(bank_open),
    .ref_grant_i(grant), .ref_req_o(req), .ref_urgent_o(urgent),
    .ref_busy_o(busy), .cke_o(cke), .cmd_o(cmd), .a10_o(a10)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog (all) actual=%0d expected<=%0d", cycles, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R1 reset values, R10 cke rises after first edge
  task automatic do_reset(input logic hot);
    @(negedge clk);
    rst_n = 1'b0; grant = 1'b0; bank_open = 1'b0; temp_hot = hot;
    tick(2);
    chk(cmd == C_DES, "R1 cmd in reset", cmd, C_DES);
    chk({req, urgent, busy, cke, a10} == 5'b0, "R1 flags in reset",
        {req, urgent, busy, cke, a10}, 0);
    rst_n = 1'b1;
    tick(1);
    chk(cke == 1'b1, "R10 cke after reset", cke, 1);
  endtask

  task automatic test_idle_grant();
    do_reset(1'b0);
    grant = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      chk(!busy && cmd == C_DES, "R8 grant ignored without debt", {busy, cmd}, C_DES);
    end
    grant = 1'b0;
  endtask

  // R2 / R3: request due exactly N edges after reset release (1 already taken)
  task automatic test_interval(input logic hot);
    int n;
    n = hot ? NH : NN;
    do_reset(hot);
    tick(n - 2);
    chk(req == 1'b0, hot ? "R3 req before hot interval" : "R2 req before interval", req, 0);
    tick(1);
    chk(req == 1'b1, hot ? "R3 req at hot interval" : "R2 req at interval", req, 1);
  endtask

  // R4 R5 R7 R10 R11: open bank path
  task automatic test_seq_open();
    grant = 1'b1; bank_open = 1'b1;
    tick(1);
    chk(cmd == C_PRE && a10 && busy, "R4 precharge all", {cmd, a10, busy}, {C_PRE, 2'b11});
    grant = 1'b0; bank_open = 1'b0;          // R11: changes while busy
    for (int i = 1; i < TRP; i++) begin
      tick(1);
      chk(cmd == C_NOP && busy, "R5 NOP during tRP", cmd, C_NOP);
    end
    tick(1);
    chk(cmd == C_REF && cke, "R5 REFRESH after tRP", cmd, C_REF);
    grant = 1'b1; bank_open = 1'b1;          // R11 again
    for (int i = 1; i < TRFC; i++) begin
      tick(1);
      chk(cmd == C_NOP && busy && cke, "R7 NOP during tRFC", cmd, C_NOP);
    end
    grant = 1'b0;
    tick(1);
    chk(!busy && cmd == C_DES, "R7 busy released after tRFC", {busy, cmd}, C_DES);
    chk(req == 1'b0, "R8 req cleared by refresh", req, 0);
  endtask

  // R6: closed bank path
  task automatic test_seq_closed();
    grant = 1'b1; bank_open = 1'b0;
    tick(1);
    chk(cmd == C_REF && !a10 && busy, "R6 direct REFRESH", cmd, C_REF);
    grant = 1'b0;
    tick(TRFC - 1);
    chk(busy && cmd == C_NOP, "R7 still busy at tRFC-1", {busy, cmd}, {1'b1, C_NOP});
    tick(1);
    chk(!busy, "R7 idle at tRFC", busy, 0);
  endtask

  // R9 saturation and lost expiries, R7 back-to-back spacing
  task automatic test_saturate();
    int refs, last, gap_bad;
    do_reset(1'b0);
    tick(8 * NN - 2);
    chk(req && !urgent, "R9 not urgent at 7 pending", urgent, 0);
    tick(1);
    chk(urgent == 1'b1, "R9 urgent at 8 pending", urgent, 1);
    tick(NN);
    chk(urgent == 1'b1, "R9 urgent after lost expiry", urgent, 1);
    grant = 1'b1; bank_open = 1'b0;
    refs = 0; last = -1; gap_bad = 0;
    for (int c = 0; c < 10 * (TRFC + 1); c++) begin
      tick(1);
      if (cmd == C_REF) begin
        if (last >= 0 && c - last != TRFC + 1) gap_bad = c - last;
        refs++; last = c;
      end
      if (refs == 1 && c == last + 1)
        chk(urgent == 1'b0, "R9 urgent drops after one refresh", urgent, 0);
      if (cmd == C_PRE) gap_bad = -1;
    end
    grant = 1'b0;
    chk(refs == 8, "R9 exactly 8 refreshes clear debt", refs, 8);
    chk(gap_bad == 0, "R7 back-to-back spacing", gap_bad, 0);
    chk(!req && !busy, "R8 debt empty", {req, busy}, 0);
  endtask

  initial begin
    test_idle_grant();
    test_interval(1'b0);
    test_seq_open();
    test_interval(1'b1);
    test_seq_closed();
    test_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule